// File: doc/BRIEF.md
# Line-Doubling Video Deinterlacer

This block sits on a streaming video path. It receives fields or frames as an AXI4-Stream of pixels and sends progressive frames out on a second AXI4-Stream. For an interlaced field, each incoming line is written into a single line store and forwarded as it arrives. The same line is then read back and sent a second time. Each output frame therefore carries twice as many lines as the field that produced it. Frames that are marked progressive leave the block exactly as they entered, including their start-of-frame and end-of-line flags.

The line width, the line count, the interlaced flag and a two-bit field selector come from static configuration inputs. They are sampled only when a field starts, so changing them in the middle of a field has no effect on that field. On the first beat of a field, `s_tuser[0]` marks the start and `s_tuser[1]` gives its parity. A field whose parity is not selected is swallowed at full rate and produces no output. The controller uses five states:
- IDLE waits for a start beat.
- FILL forwards a line and writes it into the store.
- REPLAY reads the stored copy out.
- PASS forwards progressive video.
- DROP discards a field.

The transitions are:
- IDLE→FILL/PASS/DROP on a start beat.
- FILL→REPLAY after the last pixel of a line.
- REPLAY→FILL after a line that is not the last.
- REPLAY/PASS/DROP→IDLE after the last pixel of the last line.

Top module: `bob_deinterlacer`

## Requirements
- R1: For a kept interlaced field, each input line appears on the output twice in a row, with identical pixel data in the same order.
- R2: An output frame from a field of H lines holds 2·H lines. `m_tuser` is 1 only on its very first beat, and `m_tlast` is 1 on the last pixel of every output line.
- R3: With `cfg_interlaced`=0, every beat is forwarded unchanged: the same data, `m_tuser` equal to the input `s_tuser[0]`, and `m_tlast` equal to the input `s_tlast`.
- R4: A field's parity is taken from `s_tuser[1]` on its start beat, where 0 means F0 and 1 means F1. `cfg_field_sel[0]`=1 keeps F0 fields and `cfg_field_sel[1]`=1 keeps F1 fields. The value 2'b11 keeps both, so the output frame rate equals the field rate. The value 2'b00 drops every interlaced field.
- R5: An unselected field is accepted with `s_tready` high on every beat after its start beat, and it produces no output beat.
- R6: While the block is waiting for a field, input beats without `s_tuser[0]` are accepted and discarded without producing output.
- R7: While the second copy of a line is being sent, `s_tready` is 0.
- R8: While `m_tvalid`=1 and `m_tready`=0, the output beat stays valid and its data and `m_tlast` stay unchanged. No beat is lost or duplicated beyond the line doubling.
- R9: Width, height, interlaced flag and field selector are captured on the start beat. Changing them during a field does not alter that field's output.
- R10: After reset, `m_tvalid` is 0 and no field is in progress.
- R11: Line widths from 1 up to MAX_WIDTH pixels are doubled correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_width | input | WID_W | Pixels per line (1..MAX_WIDTH) |
| cfg_height | input | LIN_W | Lines per field or frame (1..MAX_LINES) |
| cfg_interlaced | input | 1 | 1 = interlaced fields, 0 = progressive pass-through |
| cfg_field_sel | input | 2 | Bit 0 keeps F0, bit 1 keeps F1 |
| s_tdata | input | DATA_W | Input pixel |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted |
| s_tuser | input | 2 | Bit 0 start of field, bit 1 field parity |
| s_tlast | input | 1 | Input end of line |
| m_tdata | output | DATA_W | Output pixel |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream ready |
| m_tuser | output | 1 | Output start of frame |
| m_tlast | output | 1 | Output end of line |

## Verification
The bench builds the block with MAX_WIDTH=8, MAX_LINES=8 and DATA_W=16. With these values a line that fills the whole store, and a one-pixel line whose replay lasts a single beat, are cheap to exercise. Each field is small enough that every mode, progressive frames, stray beats and a mid-field configuration change fit in one short run under random backpressure. The pixel values encode the field sequence, line and column, so any reordering, loss or extra copy shows up as a data mismatch.

// File: rtl/bob_pkg.sv
package bob_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_REPLAY,
        ST_PASS,
        ST_DROP
    } bob_state_t;

    localparam int SEL_F0 = 0;
    localparam int SEL_F1 = 1;
endpackage

// File: rtl/bob_line_buf.sv
module bob_line_buf #(
    parameter int DATA_W = 24,
    parameter int DEPTH  = 1024,
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/bob_ctrl.sv
module bob_ctrl import bob_pkg::*; #(
    parameter int MAX_WIDTH = 1024,
    parameter int MAX_LINES = 1080,
    localparam int PIX_W = (MAX_WIDTH > 1) ? $clog2(MAX_WIDTH) : 1,
    localparam int WID_W = $clog2(MAX_WIDTH + 1),
    localparam int LIN_W = $clog2(MAX_LINES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WID_W-1:0] cfg_width,
    input  logic [LIN_W-1:0] cfg_height,
    input  logic             cfg_interlaced,
    input  logic [1:0]       cfg_field_sel,
    input  logic             s_tvalid,
    input  logic             s_sof,
    input  logic             s_odd,
    input  logic             s_last,
    input  logic             m_tready,
    output logic             s_tready,
    output logic             m_tvalid,
    output logic             m_tuser,
    output logic             m_tlast,
    output logic             replay,
    output logic             buf_wr,
    output logic [PIX_W-1:0] pix
);
    bob_state_t state_q, state_d;
    logic [PIX_W-1:0] pix_q;
    logic [LIN_W-1:0] line_q;
    logic [WID_W-1:0] width_q;
    logic [LIN_W-1:0] height_q;
    logic last_pix, last_line, start, keep, in_hs, out_hs;

    assign last_pix  = (WID_W'(pix_q) + WID_W'(1)) == width_q;
    assign last_line = (line_q + LIN_W'(1)) == height_q;
    assign keep      = s_odd ? cfg_field_sel[SEL_F1] : cfg_field_sel[SEL_F0];
    assign start     = (state_q == ST_IDLE) && s_tvalid && s_sof;
    assign in_hs     = s_tvalid && s_tready;
    assign out_hs    = m_tvalid && m_tready;
    assign pix       = pix_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = !cfg_interlaced ? ST_PASS : (keep ? ST_FILL : ST_DROP);
            ST_FILL:   if (in_hs && last_pix) state_d = ST_REPLAY;
            ST_REPLAY: if (out_hs && last_pix) state_d = last_line ? ST_IDLE : ST_FILL;
            ST_PASS,
            ST_DROP:   if (in_hs && last_pix && last_line) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        s_tready = 1'b0;
        m_tvalid = 1'b0;
        m_tuser  = 1'b0;
        m_tlast  = 1'b0;
        replay   = 1'b0;
        buf_wr   = 1'b0;
        unique case (state_q)
            ST_IDLE:   s_tready = s_tvalid && !s_sof;
            ST_FILL: begin
                s_tready = m_tready;
                m_tvalid = s_tvalid;
                m_tuser  = (line_q == '0) && (pix_q == '0);
                m_tlast  = last_pix;
                buf_wr   = s_tvalid && m_tready;
            end
            ST_REPLAY: begin
                m_tvalid = 1'b1;
                m_tlast  = last_pix;
                replay   = 1'b1;
            end
            ST_PASS: begin
                s_tready = m_tready;
                m_tvalid = s_tvalid;
                m_tuser  = s_sof;
                m_tlast  = s_last;
            end
            ST_DROP:   s_tready = 1'b1;
            default:   s_tready = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_q    <= '0;
            line_q   <= '0;
            width_q  <= WID_W'(1);
            height_q <= LIN_W'(1);
        end else if (start) begin
            pix_q    <= '0;
            line_q   <= '0;
            width_q  <= cfg_width;
            height_q <= cfg_height;
        end else begin
            unique case (state_q)
                ST_FILL:
                    if (in_hs) pix_q <= last_pix ? '0 : pix_q + PIX_W'(1);
                ST_REPLAY:
                    if (out_hs) begin
                        if (last_pix) begin
                            pix_q  <= '0;
                            line_q <= line_q + LIN_W'(1);
                        end else begin
                            pix_q <= pix_q + PIX_W'(1);
                        end
                    end
                ST_PASS,
                ST_DROP:
                    if (in_hs) begin
                        if (last_pix) begin
                            pix_q  <= '0;
                            line_q <= line_q + LIN_W'(1);
                        end else begin
                            pix_q <= pix_q + PIX_W'(1);
                        end
                    end
                default: ;
            endcase
        end
    end

    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DROP) |-> !m_tvalid && s_tready); // R5

    AST_REPLAY_STALLS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REPLAY) |-> !s_tready); // R7

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) && ($past(state_q) != ST_IDLE) |-> $stable(width_q) && $stable(height_q)); // R9
endmodule

// File: rtl/bob_deinterlacer.sv
module bob_deinterlacer #(
    parameter int MAX_WIDTH = 1024,
    parameter int MAX_LINES = 1080,
    parameter int DATA_W    = 24,
    localparam int PIX_W = (MAX_WIDTH > 1) ? $clog2(MAX_WIDTH) : 1,
    localparam int WID_W = $clog2(MAX_WIDTH + 1),
    localparam int LIN_W = $clog2(MAX_LINES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WID_W-1:0]  cfg_width,
    input  logic [LIN_W-1:0]  cfg_height,
    input  logic              cfg_interlaced,
    input  logic [1:0]        cfg_field_sel,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic [1:0]        s_tuser,
    input  logic              s_tlast,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic              m_tuser,
    output logic              m_tlast
);
    logic             replay;
    logic             buf_wr;
    logic [PIX_W-1:0] pix;
    logic [DATA_W-1:0] buf_rd;

    bob_ctrl #(
        .MAX_WIDTH (MAX_WIDTH),
        .MAX_LINES (MAX_LINES)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_width      (cfg_width),
        .cfg_height     (cfg_height),
        .cfg_interlaced (cfg_interlaced),
        .cfg_field_sel  (cfg_field_sel),
        .s_tvalid       (s_tvalid),
        .s_sof          (s_tuser[0]),
        .s_odd          (s_tuser[1]),
        .s_last         (s_tlast),
        .m_tready       (m_tready),
        .s_tready       (s_tready),
        .m_tvalid       (m_tvalid),
        .m_tuser        (m_tuser),
        .m_tlast        (m_tlast),
        .replay         (replay),
        .buf_wr         (buf_wr),
        .pix            (pix)
    );

    bob_line_buf #(
        .DATA_W (DATA_W),
        .DEPTH  (MAX_WIDTH)
    ) u_line (
        .clk     (clk),
        .wr_en   (buf_wr),
        .wr_addr (pix),
        .wr_data (s_tdata),
        .rd_addr (pix),
        .rd_data (buf_rd)
    );

    assign m_tdata = replay ? buf_rd : s_tdata;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast)); // R8
endmodule

// File: tb/bob_deinterlacer_test.sv
`timescale 1ns/1ps
module bob_deinterlacer_test;
    localparam int MW = 8;
    localparam int ML = 8;
    localparam int DW = 16;
    localparam int WID_W = $clog2(MW + 1);
    localparam int LIN_W = $clog2(ML + 1);

    logic clk = 1'b0;
    logic rst_n;
    logic [WID_W-1:0] cfg_width;
    logic [LIN_W-1:0] cfg_height;
    logic cfg_interlaced;
    logic [1:0] cfg_field_sel;
    logic [DW-1:0] s_tdata;
    logic s_tvalid, s_tready, s_tlast;
    logic [1:0] s_tuser;
    logic [DW-1:0] m_tdata;
    logic m_tvalid, m_tready, m_tuser, m_tlast;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_frames = 0;
    int got_frames = 0;
    int seq = 0;
    bit bp_en = 0;
    logic [DW+1:0] exp_q[$];
    bit prev_stall = 0;
    logic [DW-1:0] prev_d;
    logic prev_l;

    always #2.5 clk = ~clk;

    bob_deinterlacer #(.MAX_WIDTH(MW), .MAX_LINES(ML), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_width(cfg_width), .cfg_height(cfg_height),
        .cfg_interlaced(cfg_interlaced), .cfg_field_sel(cfg_field_sel),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .s_tuser(s_tuser), .s_tlast(s_tlast),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tuser(m_tuser), .m_tlast(m_tlast)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    function automatic logic [DW-1:0] pv(input int s, input int l, input int p);
        return DW'(((s & 255) << 8) | ((l & 15) << 4) | (p & 15));
    endfunction

    task automatic drive_beat(input logic [DW-1:0] d, input bit sof, input bit odd,
                              input bit last, output int stalls);
        bit hs;
        stalls = 0;
        if ($urandom % 4 == 0) begin
            @(posedge clk); #1;
        end
        s_tdata  = d;
        s_tuser  = {odd, sof};
        s_tlast  = last;
        s_tvalid = 1'b1;
        forever begin
            @(negedge clk);
            hs = s_tready;
            @(posedge clk);
            if (hs) break;
            stalls++;
        end
        #1;
        s_tvalid = 1'b0;
        s_tuser  = 2'b00;
        s_tlast  = 1'b0;
    endtask

    task automatic send_field(input bit odd, input bit mid_change);
        int w, h, st, drop_stalls;
        bit il, keep;
        logic [1:0] sv_sel;
        logic [WID_W-1:0] sv_w;
        w = int'(cfg_width);
        h = int'(cfg_height);
        il = cfg_interlaced;
        keep = !il || cfg_field_sel[odd];
        sv_sel = cfg_field_sel;
        sv_w = cfg_width;
        drop_stalls = 0;
        seq++;
        if (keep) begin
            exp_frames++;
            for (int l = 0; l < h; l++) begin
                for (int c = 0; c < (il ? 2 : 1); c++) begin
                    for (int p = 0; p < w; p++) begin
                        exp_q.push_back({(l == 0 && p == 0 && c == 0), (p == w - 1), pv(seq, l, p)});
                    end
                end
            end
        end
        for (int l = 0; l < h; l++) begin
            for (int p = 0; p < w; p++) begin
                drive_beat(pv(seq, l, p), (l == 0 && p == 0), odd, (p == w - 1), st);
                if (mid_change && l == 0 && p == 0) begin
                    cfg_width = WID_W'(1);
                    cfg_field_sel = 2'b00;
                end
                if (!keep && !(l == 0 && p == 0)) drop_stalls += st;
                if (keep && il && p == w - 1) begin
                    @(negedge clk);
                    check(s_tready == 1'b0, "R7 input stalled in replay", s_tready, 0);
                    @(posedge clk); #1;
                end
            end
        end
        if (mid_change) begin
            cfg_width = sv_w;
            cfg_field_sel = sv_sel;
        end
        if (!keep) check(drop_stalls == 0, "R5 dropped field stalls", drop_stalls, 0);
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall)
                check(m_tvalid && m_tdata == prev_d && m_tlast == prev_l,
                      "R8 held under backpressure", int'(m_tdata), int'(prev_d));
            if (m_tvalid && m_tready) begin
                if (m_tuser) got_frames++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 R6 unexpected output beat", int'(m_tdata), 0);
                end else begin
                    logic [DW+1:0] e;
                    e = exp_q.pop_front();
                    check({m_tuser, m_tlast, m_tdata} == e, "R1 R2 R3 R4 R9 R11 beat",
                          int'({m_tuser, m_tlast, m_tdata}), int'(e));
                end
            end
            prev_stall = m_tvalid && !m_tready;
            prev_d = m_tdata;
            prev_l = m_tlast;
        end
    end

    initial begin
        m_tready = 1'b0;
        forever begin
            @(posedge clk); #1;
            m_tready = bp_en ? ($urandom % 3 != 0) : 1'b1;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
        finish_run();
    end

    initial begin
        int st;
        rst_n = 1'b0;
        s_tdata = '0; s_tvalid = 1'b0; s_tuser = 2'b00; s_tlast = 1'b0;
        cfg_width = WID_W'(4); cfg_height = LIN_W'(3);
        cfg_interlaced = 1'b1; cfg_field_sel = 2'b11;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(m_tvalid == 1'b0, "R10 reset output idle", m_tvalid, 0);
        @(posedge clk); #1;

        send_field(1'b0, 1'b0);            // R1 R4 both kept
        send_field(1'b1, 1'b0);
        bp_en = 1;
        send_field(1'b0, 1'b0);
        cfg_field_sel = 2'b01;             // R4 F0 only
        send_field(1'b0, 1'b0);
        send_field(1'b1, 1'b0);
        cfg_field_sel = 2'b10;             // R4 F1 only
        send_field(1'b0, 1'b0);
        send_field(1'b1, 1'b0);
        cfg_field_sel = 2'b00;             // R4 all dropped
        send_field(1'b1, 1'b0);
        for (int i = 0; i < 3; i++) begin  // R6 stray beats
            drive_beat(DW'(16'hEE00 + i), 1'b0, 1'b0, 1'b0, st);
            check(st == 0, "R6 stray beat accepted", st, 0);
        end
        cfg_interlaced = 1'b0;             // R3 progressive
        send_field(1'b1, 1'b0);
        send_field(1'b0, 1'b0);
        cfg_interlaced = 1'b1;
        cfg_field_sel = 2'b11;
        send_field(1'b0, 1'b1);            // R9 mid-field change
        cfg_width = WID_W'(MW);            // R11 full width
        cfg_height = LIN_W'(2);
        send_field(1'b1, 1'b0);
        cfg_width = WID_W'(1);             // R11 single pixel
        send_field(1'b0, 1'b0);

        for (int i = 0; i < 2000 && exp_q.size() != 0; i++) @(posedge clk);
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R1 all expected beats seen", exp_q.size(), 0);
        check(got_frames == exp_frames, "R2 R4 output frame count", got_frames, exp_frames);
        finish_run();
    end
endmodule